// File: doc/BRIEF.md
# Slot Status Event Drain Engine

This block services a hot-plug interrupt in hardware. A host pulses `start`, and the engine then drains the slot status register through a simple register request port. It reads the register and masks the value down to the event-notification bits. It writes any events it found back to the register, which clears those bits, and then reads again at once. It repeats this until a read shows no events left. The repeated read closes a race. An event that is raised between a read and its clear would otherwise stay set, and the port would never raise another edge-triggered interrupt.

The loop has a bound. After the first read the engine allows a fixed number of re-reads. If the last allowed read still shows events, the engine clears them and raises a stuck-bit flag. A read that returns all ones means the device did not respond, and the sequence stops with no write. When the sequence ends, the engine pulses `done` for one cycle. It reports the OR of every event set it cleared, whether any event was handled, and the two error flags.

The register port is a request/acknowledge channel, and the register decides the pace. The engine holds `reg_req`, `reg_we` and `reg_wdata` steady until it sees `reg_ack`. It accepts read data only in the cycle where `reg_ack` is high. The engine is always ready for the response, so the only back-pressure is the register's acknowledge latency, which may be any number of cycles.

Top module: `slot_evt_drain`

## Requirements
- R1: Only these event bits are kept from a read: bit 0 (attention button), bit 1 (power fault), bit 3 (presence changed), bit 4 (command completed) and bit 8 (link state changed). Every other bit is dropped from the written value and from `evt_mask`.
- R2: When the kept set is non-zero, the engine writes exactly that set back (`reg_we`=1). When the kept set is zero, it issues no write.
- R3: `evt_mask` is the OR of every set written back during the sequence. It is valid while `done` is high.
- R4: After every write acknowledge, the next request is a read. The engine keeps looping for as long as a read shows kept events.
- R5: At most 6 re-reads follow the first read, so a sequence has at most 7 reads. If the seventh read still has kept events, they are written back, `stuck` is 1 at done, and no further read is made.
- R6: A read of 16'hFFFF ends the sequence with no write, and `no_resp` is 1 at done.
- R7: While `pf_reported` is 1, bit 1 is removed from the kept set before write-back and accumulation.
- R8: `handled` is 1 at done exactly when `evt_mask` is non-zero.
- R9: A `start` pulse while idle launches a sequence. `done` is high for exactly one cycle. A `start` while `busy` is high (including the done cycle) is ignored. Results hold until the next accepted start.
- R10: A pending request keeps `reg_req`, `reg_we` and `reg_wdata` stable until `reg_ack`. Any acknowledge latency is tolerated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a drain sequence when idle |
| pf_reported | input | 1 | Suppress the power-fault event bit |
| busy | output | 1 | Sequence in progress (includes the done cycle) |
| done | output | 1 | One-cycle end-of-sequence pulse |
| evt_mask | output | 16 | Accumulated cleared events |
| handled | output | 1 | At least one event cleared |
| stuck | output | 1 | Retry limit reached with events present |
| no_resp | output | 1 | All-ones read seen |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_wdata | output | 16 | Write data (event bits to clear) |
| reg_ack | input | 1 | Access acknowledge from the register |
| reg_rdata | input | 16 | Read data, valid with `reg_ack` |

## Verification
The sweeps cover every combination of the five event bits, with and without power-fault suppression. Each combination is run with no race, with an event landing between a read and its clear, and with a chain of such events. A design that cleared from its first read only would leave the late event set and report a short mask. Runs with a bit that never clears, or with a new event after every clear, probe the retry bound: an off-by-one design makes six or eight reads instead of seven, or misreports `stuck`. All-ones reads on the first and second access check that the engine never writes after a non-response. A second `start` during each sequence checks that a busy engine ignores it.

// File: rtl/sde_pkg.sv
package sde_pkg;
  localparam int unsigned SDE_W = 16;

  localparam int unsigned BIT_ATTN = 0;
  localparam int unsigned BIT_PFLT = 1;
  localparam int unsigned BIT_PRES = 3;
  localparam int unsigned BIT_CMDC = 4;
  localparam int unsigned BIT_LINK = 8;

  localparam logic [SDE_W-1:0] EVT_KEEP =
      (SDE_W'(1) << BIT_ATTN) | (SDE_W'(1) << BIT_PFLT) |
      (SDE_W'(1) << BIT_PRES) | (SDE_W'(1) << BIT_CMDC) |
      (SDE_W'(1) << BIT_LINK);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_FIN  = 2'd3
  } sde_state_e;
endpackage

// File: rtl/sde_evt_filter.sv
module sde_evt_filter
  import sde_pkg::*;
#(
  parameter int unsigned W = SDE_W
) (
  input  logic [W-1:0] raw,
  input  logic         pf_block,
  output logic [W-1:0] kept,
  output logic         any_evt,
  output logic         all_ones
);
  logic [W-1:0] keep_sel;

  always_comb begin
    keep_sel = EVT_KEEP;
    if (pf_block) keep_sel[BIT_PFLT] = 1'b0;
    kept     = raw & keep_sel;
    any_evt  = |kept;
    all_ones = &raw;
  end
endmodule

// File: rtl/sde_retry_ctr.sv
module sde_retry_ctr #(
  parameter int unsigned LIMIT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int unsigned CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (inc && (cnt_q != LIM)) cnt_q <= cnt_q + 1'b1;
  end

  assign at_limit = (cnt_q == LIM);
endmodule

// File: rtl/sde_accum.sv
module sde_accum #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] acc
);
  logic [W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   acc_q <= '0;
    else if (clr) acc_q <= '0;
    else if (en)  acc_q <= acc_q | din;
  end

  assign acc = acc_q;
endmodule

// File: rtl/slot_evt_drain.sv
module slot_evt_drain
  import sde_pkg::*;
#(
  parameter int unsigned MAX_REREADS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             pf_reported,
  output logic             busy,
  output logic             done,
  output logic [SDE_W-1:0] evt_mask,
  output logic             handled,
  output logic             stuck,
  output logic             no_resp,
  output logic             reg_req,
  output logic             reg_we,
  output logic [SDE_W-1:0] reg_wdata,
  input  logic             reg_ack,
  input  logic [SDE_W-1:0] reg_rdata
);
  sde_state_e       state_q, state_d;
  logic [SDE_W-1:0] kept_q;
  logic             stuck_q, noresp_q;

  logic [SDE_W-1:0] flt_kept;
  logic             flt_any, flt_ones;
  logic             launch, rd_done, wr_done;
  logic             at_limit;
  logic [SDE_W-1:0] acc;

  assign launch  = (state_q == ST_IDLE) && start;
  assign rd_done = (state_q == ST_RD) && reg_ack;
  assign wr_done = (state_q == ST_WR) && reg_ack;

  sde_evt_filter #(.W(SDE_W)) u_filter (
    .raw      (reg_rdata),
    .pf_block (pf_reported),
    .kept     (flt_kept),
    .any_evt  (flt_any),
    .all_ones (flt_ones)
  );

  sde_retry_ctr #(.LIMIT(MAX_REREADS)) u_retry (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (launch),
    .inc      (wr_done && !at_limit),
    .at_limit (at_limit)
  );

  sde_accum #(.W(SDE_W)) u_accum (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (launch),
    .en    (rd_done && !flt_ones && flt_any),
    .din   (flt_kept),
    .acc   (acc)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_RD;
      ST_RD: if (reg_ack) begin
        if (flt_ones)     state_d = ST_FIN;
        else if (flt_any) state_d = ST_WR;
        else              state_d = ST_FIN;
      end
      ST_WR: if (reg_ack) state_d = at_limit ? ST_FIN : ST_RD;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      kept_q   <= '0;
      stuck_q  <= 1'b0;
      noresp_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (launch) begin
        stuck_q  <= 1'b0;
        noresp_q <= 1'b0;
      end
      if (rd_done) begin
        if (flt_ones)     noresp_q <= 1'b1;
        else if (flt_any) kept_q   <= flt_kept;
      end
      if (wr_done && at_limit) stuck_q <= 1'b1;
    end
  end

  assign reg_req   = (state_q == ST_RD) || (state_q == ST_WR);
  assign reg_we    = (state_q == ST_WR);
  assign reg_wdata = (state_q == ST_WR) ? kept_q : '0;

  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_FIN);
  assign evt_mask = acc;
  assign handled  = |acc;
  assign stuck    = stuck_q;
  assign no_resp  = noresp_q;
endmodule

// File: rtl/sde_drain_chk.sv
module sde_drain_chk
  import sde_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             pf_reported,
  input logic             busy,
  input logic             done,
  input logic [SDE_W-1:0] evt_mask,
  input logic             handled,
  input logic             stuck,
  input logic             no_resp,
  input logic             reg_req,
  input logic             reg_we,
  input logic [SDE_W-1:0] reg_wdata,
  input logic             reg_ack
);
  // R1, R2: a write carries only kept event bits and is never empty
  p_write_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we) |-> ((reg_wdata & ~EVT_KEEP) == '0) && (reg_wdata != '0));

  // R1: the reported mask never holds a plain status bit
  p_mask_events_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((evt_mask & ~EVT_KEEP) == '0));

  // R7: a suppressed power fault is never written
  p_pf_suppressed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && pf_reported) |-> !reg_wdata[BIT_PFLT]);

  // R4: a completed write is followed by a re-read or by the end
  p_reread_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && reg_ack) |=> ((reg_req && !reg_we) || done));

  // R8: handled matches a non-zero mask
  p_handled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (handled == (evt_mask != '0)));

  // R5, R6: stuck implies events were handled; stuck and no response exclusive
  p_stuck_handled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && stuck) |-> (handled && !no_resp));

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: a start while busy does not disturb the running sequence
  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);

  // R10: a pending request holds steady until acknowledged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_we) && $stable(reg_wdata)));
endmodule

bind slot_evt_drain sde_drain_chk u_sde_drain_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .pf_reported (pf_reported),
  .busy        (busy),
  .done        (done),
  .evt_mask    (evt_mask),
  .handled     (handled),
  .stuck       (stuck),
  .no_resp     (no_resp),
  .reg_req     (reg_req),
  .reg_we      (reg_we),
  .reg_wdata   (reg_wdata),
  .reg_ack     (reg_ack)
);

// File: tb/slot_evt_drain_bench.sv
module slot_evt_drain_bench;
  localparam logic [15:0] EVT = 16'h011B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        pf_reported = 1'b0;
  logic        busy, done, handled, stuck, no_resp;
  logic [15:0] evt_mask;
  logic        reg_req, reg_we;
  logic [15:0] reg_wdata;
  logic        reg_ack = 1'b0;
  logic [15:0] reg_rdata = 16'h0;

  always #10 clk = ~clk;

  slot_evt_drain u_slot_evt_drain (
    .clk(clk), .rst_n(rst_n), .start(start), .pf_reported(pf_reported),
    .busy(busy), .done(done), .evt_mask(evt_mask), .handled(handled),
    .stuck(stuck), .no_resp(no_resp), .reg_req(reg_req), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata)
  );

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  // register model
  logic [15:0] m_reg, m_stuck;
  logic [15:0] m_inj [0:7];
  int m_nr_at, m_reads, m_writes, m_illeg, m_lat, lat_seed;

  // expected
  logic [15:0] e_mask;
  logic        e_stuck, e_nr;
  int          e_reads, e_writes;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  // register responder: effects applied when ack is raised
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_ack) begin
        reg_ack = 1'b0;
      end else if (reg_req) begin
        if (m_lat > 0) m_lat--;
        else begin
          reg_ack = 1'b1;
          if (reg_we) begin
            if (((reg_wdata & ~EVT) != 0) || (reg_wdata == 0) ||
                (pf_reported && reg_wdata[1])) m_illeg++;
            m_reg = m_reg & ~reg_wdata;
            m_writes++;
          end else begin
            reg_rdata = (m_reads == m_nr_at) ? 16'hFFFF : (m_reg | m_stuck);
            if (m_reads < 8) m_reg = m_reg | m_inj[m_reads];
            m_reads++;
          end
          m_lat = (lat_seed + m_reads * 3 + m_writes) % 4;
        end
      end
    end
  end

  task automatic reference(logic [15:0] init, logic pf);
    logic [15:0] r, v, k;
    int rd, rr;
    r = init; e_mask = 0; e_stuck = 0; e_nr = 0; e_writes = 0; rd = 0; rr = 0;
    for (int it = 0; it < 8; it++) begin
      v = (rd == m_nr_at) ? 16'hFFFF : (r | m_stuck);
      r = r | m_inj[rd];
      rd++;
      if (v == 16'hFFFF) begin e_nr = 1; break; end
      k = v & EVT;
      if (pf) k[1] = 1'b0;
      if (k == 0) break;
      r = r & ~k; e_writes++; e_mask = e_mask | k;
      if (rr == 6) begin e_stuck = 1; break; end
      rr++;
    end
    e_reads = rd;
  endtask

  function automatic logic [15:0] spread(logic [4:0] p);
    return {7'b0, p[4], 3'b0, p[3], p[2], 1'b0, p[1], p[0]};
  endfunction

  initial begin
    int got;
    logic [15:0] held;
    m_reg = 0; m_stuck = 0; m_nr_at = -1; m_reads = 0; m_writes = 0;
    m_illeg = 0; m_lat = 0; lat_seed = 0;
    for (int i = 0; i < 8; i++) m_inj[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check("R9 reset busy", {15'b0, busy}, 16'h0);
    check("R9 reset done", {15'b0, done}, 16'h0);
    check("R10 reset req", {15'b0, reg_req}, 16'h0);
    check("R3 reset mask", evt_mask, 16'h0);

    for (int sc = 0; sc < 7; sc++) begin
      for (int pfv = 0; pfv < 2; pfv++) begin
        for (int p = 0; p < 32; p++) begin
          logic [15:0] init;
          init = spread(5'(p)) | ((p % 2 == 1) ? 16'h60E4 : 16'h0024);
          for (int i = 0; i < 8; i++) m_inj[i] = 0;
          m_stuck = 0; m_nr_at = -1;
          case (sc)
            1: m_inj[0] = 16'h0100;
            2: begin m_inj[0] = 16'h0008; m_inj[1] = 16'h0100; m_inj[2] = 16'h0010; end
            3: m_stuck = 16'h0010;
            4: for (int i = 0; i < 8; i++) m_inj[i] = 16'h0001;
            5: m_nr_at = 0;
            6: m_nr_at = 1;
            default: ;
          endcase
          pf_reported = pfv[0];
          lat_seed = p + sc;
          m_reg = init; m_reads = 0; m_writes = 0; m_illeg = 0;
          m_lat = lat_seed % 3;
          reference(init, pfv[0]);

          got = 0;
          for (int t = 0; t < 200 && !got; t++) begin
            start = (t == 0 || t == 2) ? 1'b1 : 1'b0;
            @(negedge clk);
            if (done) got = 1;
          end
          start = 1'b0;
          check("R9 done seen", 16'(got), 16'h1);
          check("R3 R1 R7 mask", evt_mask, e_mask);
          check("R8 handled", {15'b0, handled}, {15'b0, e_mask != 0});
          check("R5 stuck", {15'b0, stuck}, {15'b0, e_stuck});
          check("R6 no_resp", {15'b0, no_resp}, {15'b0, e_nr});
          held = evt_mask;
          @(negedge clk);
          check("R9 done one cycle", {15'b0, done}, 16'h0);
          check("R9 start while busy ignored", {15'b0, busy}, 16'h0);
          repeat (2) @(negedge clk);
          check("R9 results held", evt_mask, held);
          check("R4 R5 read count", 16'(m_reads), 16'(e_reads));
          check("R2 R6 write count", 16'(m_writes), 16'(e_writes));
          check("R2 R10 legal writes", 16'(m_illeg), 16'h0);
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule